// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the serial front end of a small byte-wide nonvolatile store. It watches a two-wire bus (clock line plus bidirectional data line), spots bus start and stop conditions, compares the 7-bit device address with its own, and then either takes in a word address and data bytes, or returns stored bytes to the master. A single address counter serves both directions. It always points one past the last byte that was read or written, so a master can read "from where it left off" without sending an address.

After any transaction that wrote at least one data byte, the block models the internal programming time as a busy window of a fixed number of system clocks. During that window it ignores start conditions, so its address is never acknowledged. A master finds out that programming has finished by sending its address with the write direction until an acknowledge comes back. The data line is modelled as a separate input, output value and output enable. The enclosing pad logic forms the open-drain wire. The storage is a plain register file inside the block.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset the data output enable is low, every storage byte is 0x00 and the address counter is 0, so the first current-address read returns location 0.
- R2: The block acknowledges an address byte (bits 7..1 address, bit 0 direction) only when bits 7..1 equal DEV_ADDR. On a mismatch it drives nothing for the rest of the transaction.
- R3: In a write transaction (direction bit 0), the first byte after the address loads the counter. Each later byte is stored at the counter, which then advances, and every such byte is acknowledged.
- R4: A stop that ends a transaction holding at least one data byte starts a busy window of BUSY_CYCLES clocks. Within it, start conditions are ignored and the address is not acknowledged. The first write-direction address sent after the window is acknowledged.
- R5: A current-address read (direction bit 1) acknowledges the address and then shifts out the byte at the counter, bit 7 first, changing the data line only while the clock line is low. The counter then advances.
- R6: A random-address read is a write-direction address plus a word address, then a repeated start with a read-direction address. It returns the byte at that word address.
- R7: When the master acknowledges a returned byte, the block sends the byte at the next address, wrapping from the top location to 0. This applies both after a random address and from the current address.
- R8: The counter is shared by both directions: after a write whose last byte went to location n, a current-address read returns location n+1.
- R9: A master not-acknowledge after a returned byte ends the read. The block releases the data line and drives nothing until the next start condition.
- R10: A start condition at any bit position abandons the byte in progress, and the block restarts at the address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus lines |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_o | output | 1 | Value driven on the data line when enabled (0 for acknowledge) |
| sda_oe | output | 1 | Data line output enable |

## Verification
The bench polls right after a write's stop. A design that leaves start conditions live while busy would acknowledge the first poll, and one that never counts down would never acknowledge. It reads three bytes across the top of the array, which catches a counter that saturates or fails to wrap. It writes a short burst and then a single byte over it before a current-address read, which exposes a counter that tracks only reads or only writes. It also clocks a full byte after a master not-acknowledge, sends to a wrong address, and cuts off an address byte with a repeated start. A slave that keeps driving, answers a foreign address, or keeps counting stale bits would corrupt those reads.

// File: rtl/i2c_ee_pkg.sv
// Shared types for the serial byte-memory slave.
// Assumes: consumed by all modules of the block, compiled first.
package i2c_ee_pkg;

    // Bit-level protocol state of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,    // not addressed, waiting for a start
        ST_RX,      // shifting in a byte from the master
        ST_ACKSET,  // byte complete, acknowledge decided, waiting for clock low
        ST_ACK,     // slave acknowledge bit on the line
        ST_TX,      // shifting out a data byte
        ST_MACK,    // line released, waiting for the master's acknowledge
        ST_TXNEXT   // master acknowledged, load next byte at clock low
    } ee_state_t;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        RX_DEV,     // device address plus direction bit
        RX_WADDR,   // word address
        RX_WDATA    // data to store
    } rx_kind_t;

endpackage

// File: rtl/i2c_ee_line_mon.sv
// Line monitor: registers the bus lines into the system clock domain and
// flags clock edges and start/stop conditions.
// Assumes: lines are already synchronous or slow relative to clk; a start
// is a data fall with clock high, a stop a data rise with clock high.
module i2c_ee_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p, sda_p;

    // Sample both lines and keep the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_lvl <= 1'b1;
            sda_lvl <= 1'b1;
            scl_p   <= 1'b1;
            sda_p   <= 1'b1;
        end else begin
            scl_lvl <= scl_i;
            sda_lvl <= sda_i;
            scl_p   <= scl_lvl;
            sda_p   <= sda_lvl;
        end
    end

    // Decode clock edges and data transitions under a steady high clock.
    always_comb begin
        scl_rise  = scl_lvl & ~scl_p;
        scl_fall  = ~scl_lvl & scl_p;
        start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
        stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
    end

endmodule

// File: rtl/i2c_ee_busy_timer.sv
// Busy timer: models the internal programming time after a write.
// Assumes: go is a single-cycle pulse; a new go restarts the window.
module i2c_ee_busy_timer #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Load the window length on go, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (go)         cnt <= CNT_W'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R4
    busy_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));

endmodule

// File: rtl/i2c_ee_array.sv
// Register-file storage behind the slave: one write port, one
// combinational read port.
// Assumes: small depth; cleared by reset.
module i2c_ee_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Clear on reset, store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/eeprom_i2c_slave.sv
// Serial byte-memory slave: address match, byte writes, four read modes
// through a shared address counter, and a busy window that hides the
// device from the bus after a write.
// Assumes: AW <= 8 (one word-address byte); the pad forms the open-drain
// wire from sda_o/sda_oe; the system clock oversamples the bus clock.
module eeprom_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         AW          = 8,
    parameter int         BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic sda_oe
);
    import i2c_ee_pkg::*;

    localparam int DW  = 8;
    localparam int BCW = $clog2(DW);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic busy, busy_go;

    ee_state_t      st;
    rx_kind_t       kind;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0]  shreg;
    logic [AW-1:0]  ptr;
    logic           ack_go, to_tx, wrote;

    logic [DW-1:0]  rx_byte, rdata;
    logic           byte_end, mem_we, tx_load, adr_match;

    i2c_ee_line_mon u_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_ee_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (busy_go),
        .busy (busy)
    );

    i2c_ee_array #(.AW(AW), .DW(DW)) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(ptr),
        .wdata(rx_byte),
        .raddr(ptr),
        .rdata(rdata)
    );

    // Byte-completion, storage and load strobes derived from the FSM.
    always_comb begin
        rx_byte   = {shreg[DW-2:0], sda_lvl};
        byte_end  = !start_det && !stop_det && st == ST_RX && scl_rise
                    && bitcnt == LAST_BIT;
        mem_we    = byte_end && kind == RX_WDATA;
        tx_load   = !start_det && !stop_det && scl_fall
                    && ((st == ST_ACK && to_tx) || st == ST_TXNEXT);
        adr_match = rx_byte[DW-1:1] == DEV_ADDR;
        busy_go   = stop_det && wrote;
    end

    // Address counter: loaded by a word address, advanced by every access.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ptr <= '0;
        else if (byte_end && kind == RX_WADDR)    ptr <= rx_byte[AW-1:0];
        else if (mem_we || tx_load)               ptr <= ptr + AW'(1);
    end

    // Protocol FSM: bit shifting, acknowledge and data line control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            kind   <= RX_DEV;
            bitcnt <= '0;
            shreg  <= '0;
            ack_go <= 1'b0;
            to_tx  <= 1'b0;
            wrote  <= 1'b0;
            sda_oe <= 1'b0;
            sda_o  <= 1'b1;
        end else if (start_det) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            kind   <= RX_DEV;
            st     <= busy ? ST_IDLE : ST_RX;
        end else if (stop_det) begin
            sda_oe <= 1'b0;
            wrote  <= 1'b0;
            st     <= ST_IDLE;
        end else begin
            case (st)
                ST_RX: if (scl_rise) begin
                    shreg  <= rx_byte;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        st <= ST_ACKSET;
                        unique case (kind)
                            RX_DEV: begin
                                ack_go <= adr_match;
                                to_tx  <= rx_byte[0];
                                kind   <= RX_WADDR;
                            end
                            RX_WADDR: begin
                                ack_go <= 1'b1;
                                to_tx  <= 1'b0;
                                kind   <= RX_WDATA;
                            end
                            default: begin
                                ack_go <= 1'b1;
                                to_tx  <= 1'b0;
                                wrote  <= 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACKSET: if (scl_fall) begin
                    if (ack_go) begin
                        sda_oe <= 1'b1;
                        sda_o  <= 1'b0;
                        st     <= ST_ACK;
                    end else begin
                        st     <= ST_IDLE;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    if (to_tx) begin
                        shreg  <= rdata;
                        sda_o  <= rdata[DW-1];
                        sda_oe <= 1'b1;
                        st     <= ST_TX;
                    end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (bitcnt == LAST_BIT) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        st     <= ST_MACK;
                    end else begin
                        shreg  <= shreg << 1;
                        sda_o  <= shreg[DW-2];
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    st <= sda_lvl ? ST_IDLE : ST_TXNEXT;
                end
                ST_TXNEXT: if (scl_fall) begin
                    shreg  <= rdata;
                    sda_o  <= rdata[DW-1];
                    sda_oe <= 1'b1;
                    bitcnt <= '0;
                    st     <= ST_TX;
                end
                default: ;
            endcase
        end
    end

    // R4
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !start_det && !stop_det)
        |-> ($stable(sda_oe) && $stable(sda_o)));

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R10
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !busy) |=> (st == ST_RX && bitcnt == '0 && kind == RX_DEV));

endmodule

// File: tb/eeprom_i2c_slave_bench.sv
// Directed bench for the serial byte-memory slave: a bit-banged bus master
// with one task per scenario.
module eeprom_i2c_slave_bench;

    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_o, sda_oe;
    logic bus;

    int vecs = 0;
    int miss = 0;

    always #2.5 clk = ~clk;

    // Open-drain wire: either side can pull low.
    assign bus = m_sda & ~(sda_oe & ~sda_o);

    eeprom_i2c_slave u_eeprom_i2c_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl),
        .sda_i (bus),
        .sda_o (sda_o),
        .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(4);
        scl = 1'b1;   wt(4);
        m_sda = 1'b0; wt(4);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(3); m_sda = 1'b0;
        wt(5); scl = 1'b1;
        wt(4); m_sda = 1'b1;
        wt(4);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        wt(3); m_sda = b;
        wt(5); scl = 1'b1;
        wt(4); s = bus;
        wt(4); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(!mack, s);
    endtask

    // Poll with write-direction address until acknowledged.
    task automatic poll_ready(output int tries);
        logic ack;
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 40) begin
            tries++;
            bus_start();
            send_byte({DEV, 1'b0}, ack);
            bus_stop();
        end
    endtask

    task automatic write_burst(input logic [7:0] a, input logic [7:0] d0,
                               input logic [7:0] d1, input logic [7:0] d2,
                               input int n, input string req);
        logic ack;
        int tries;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk({req, " addr ack"}, ack, 1);
        send_byte(a, ack);           chk({req, " word ack"}, ack, 1);
        send_byte(d0, ack);          chk({req, " data ack"}, ack, 1);
        if (n > 1) begin send_byte(d1, ack); chk({req, " data ack"}, ack, 1); end
        if (n > 2) begin send_byte(d2, ack); chk({req, " data ack"}, ack, 1); end
        bus_stop();
        poll_ready(tries);
    endtask

    task automatic cur_read(output logic [7:0] d, input string req);
        logic ack;
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk({req, " read addr ack"}, ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    // R1: reset state.
    task automatic t_reset();
        logic [7:0] d;
        chk("R1 oe after reset", sda_oe, 0);
        cur_read(d, "R1");
        chk("R1 location 0 after reset", d, 8'h00);
    endtask

    // R3, R4: burst write, then poll during the busy window.
    task automatic t_write_poll();
        logic ack;
        int tries;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk("R3 addr ack", ack, 1);
        send_byte(8'h10, ack);       chk("R3 word ack", ack, 1);
        send_byte(8'hA5, ack);       chk("R3 data ack", ack, 1);
        send_byte(8'h3C, ack);       chk("R3 data ack", ack, 1);
        send_byte(8'h7E, ack);       chk("R3 data ack", ack, 1);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        chk("R4 no ack while busy", ack, 0);
        bus_stop();
        poll_ready(tries);
        chk("R4 poll eventually acked", (tries >= 1 && tries <= 6) ? 1 : 0, 1);
    endtask

    // R6, R5: random byte read then current-address byte read.
    task automatic t_random_then_current();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h11, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk("R6 read addr ack", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R6 random read 0x11", d, 8'h3C);
        cur_read(d, "R5");
        chk("R5 current read 0x12", d, 8'h7E);
    endtask

    // R8: counter follows writes.
    task automatic t_counter_shared();
        logic [7:0] d;
        write_burst(8'h40, 8'h99, 8'h88, 8'h00, 2, "R8");
        write_burst(8'h40, 8'h77, 8'h00, 8'h00, 1, "R8");
        cur_read(d, "R8");
        chk("R8 read after write returns n+1", d, 8'h88);
    endtask

    // R7: random sequential read across the top, then current sequential.
    task automatic t_sequential();
        logic ack;
        logic [7:0] d;
        write_burst(8'hFE, 8'hE1, 8'hF2, 8'hC3, 3, "R7");
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'hFE, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, d); chk("R7 seq byte FE", d, 8'hE1);
        recv_byte(1'b1, d); chk("R7 seq byte FF", d, 8'hF2);
        recv_byte(1'b0, d); chk("R7 seq wrap to 00", d, 8'hC3);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h10, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, d);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, d); chk("R7 current seq 0x11", d, 8'h3C);
        recv_byte(1'b0, d); chk("R7 current seq 0x12", d, 8'h7E);
        bus_stop();
    endtask

    // R9: after a master not-acknowledge, the line stays released.
    task automatic t_nack_release();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b0, d);
        recv_byte(1'b0, d);
        chk("R9 line released after nack", d, 8'hFF);
        chk("R9 oe low after nack", sda_oe, 0);
        bus_stop();
    endtask

    // R10: start mid address byte restarts the address phase.
    task automatic t_abort();
        logic ack, s;
        logic [7:0] d;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h40, ack);
        bus_start();
        clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk("R10 addr ack after abort", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R10 read after abort", d, 8'h77);
    endtask

    // R2: foreign address is ignored.
    task automatic t_wrong_addr();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({7'h51, 1'b1}, ack);
        chk("R2 no ack for foreign address", ack, 0);
        recv_byte(1'b0, d);
        chk("R2 nothing driven after mismatch", d, 8'hFF);
        bus_stop();
    endtask

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(5);
        t_reset();
        t_write_poll();
        t_random_then_current();
        t_counter_shared();
        t_sequential();
        t_nack_release();
        t_abort();
        t_wrong_addr();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

endmodule